// File: doc/BRIEF.md
# E1 Timeslot 16 Alarm Monitor

This block watches the timeslot 16 octets of a received E1 stream. The upstream framer hands over each TS16 octet with a one-cycle strobe. Each strobe also carries a flag that marks frame 0 of the CAS multiframe and a flag that says whether TS0 frame alignment is currently held. The monitor turns this into three registered status bits: a TS16 loss-of-signal flag, a TS16 alarm-indication flag and the far-end remote alarm bit. It also gives a one-cycle interrupt pulse whenever the remote alarm bit changes.

Loss of signal tracks runs of all-zero octets. The alarm-indication flag is judged once per multiframe period. A period runs from one frame-0 strobe up to the octet before the next frame-0 strobe, and its verdict is taken when that next frame-0 strobe arrives. The flag moves only after two periods in a row agree. Alignment search, line decoding and register access all sit outside the block.

Top module: `e1_ts16_alarm_mon`

## Requirements
- R1: The loss flag `ts16_los` rises on the 16th TS16 octet in an unbroken run of octets equal to 8'h00, and not on the 15th. It stays high while further zero octets arrive.
- R2: Any strobed TS16 octet that holds at least one 1 bit clears `ts16_los` and restarts the zero run.
- R3: A multiframe period is "sparse" when it holds fewer than 4 zero bits across its TS16 octets. The per-period zero count saturates at 4. Two sparse periods in a row, both closed while alignment is held, set `ts16_ais`. A single sparse period does not set it.
- R4: Two consecutive periods that each hold more than 3 zero bits clear `ts16_ais`. One such period alone leaves `ts16_ais` high.
- R5: A period whose frame-0 octet has bits [7:4] all zero shows the multiframe pattern. Two consecutive such periods clear `ts16_ais`.
- R6: A strobe with `ts0_aligned` low clears `ts16_ais`. It also discards the open period and both agreement streaks, so after alignment returns, two fresh periods must close before the flag can set again.
- R7: `ts16_ra` equals bit [2] of the latest frame-0 TS16 octet, which is the 6th bit counting from 1 at the MSB. Octets outside frame 0 never change it.
- R8: `ra_chg_irq` is high for exactly one cycle, in the cycle after a frame-0 strobe that changes `ts16_ra`. It stays low after a frame-0 strobe that leaves `ts16_ra` unchanged.
- R9: A synchronous active-high reset clears all outputs. Every output is registered and changes only in the cycle after a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ts16_vld | input | 1 | Strobe: a TS16 octet is present this cycle |
| ts16_oct | input | 8 | Received TS16 octet, MSB first on the line is bit 7 |
| mf_frame0 | input | 1 | The strobed octet belongs to frame 0 of the CAS multiframe |
| ts0_aligned | input | 1 | TS0 frame alignment is held |
| ts16_los | output | 1 | TS16 loss-of-signal flag |
| ts16_ais | output | 1 | TS16 alarm-indication flag |
| ts16_ra | output | 1 | Received TS16 remote alarm bit |
| ra_chg_irq | output | 1 | One-cycle pulse on any change of `ts16_ra` |

## Verification
Loss of signal is tried with zero runs of 15 and 16 octets, and with a run broken by a single nonzero octet. These tell the exact threshold apart from an off-by-one and show that the run restarts. The alarm-indication logic is fed periods holding exactly 3 zeros and exactly 4 zeros, which separates the fewer-than-4 boundary from its neighbours. It is also fed periods with the frame-0 pattern, so the pattern clear is checked as well as the count clear. Single-period exposures show that two agreeing periods are required. An alignment loss in the middle of a run shows that the streaks restart and that the flag is forced low. Remote-alarm tests toggle the frame-0 bit and the same bit in other frames, and repeat an unchanged value, to confirm that the interrupt fires only on a real change.

// File: rtl/e1_ts16_pkg.sv
package e1_ts16_pkg;
  localparam int OCTET_W_DEF = 8;

  typedef enum logic [1:0] {
    PV_NONE   = 2'd0,
    PV_SPARSE = 2'd1,
    PV_LIVE   = 2'd2
  } period_verdict_e;
endpackage

// File: rtl/ts16_los_det.sv
module ts16_los_det #(
  parameter int OCTET_W = 8,
  parameter int LOS_RUN = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               vld,
  input  logic [OCTET_W-1:0] oct,
  output logic               los
);
  localparam int RUN_W = $clog2(LOS_RUN + 1);

  logic [RUN_W-1:0] run_q;
  logic             los_q;
  logic             all_zero;

  assign all_zero = (oct == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
      los_q <= 1'b0;
    end else if (vld) begin
      if (all_zero) begin
        if (run_q != RUN_W'(LOS_RUN)) run_q <= run_q + 1'b1;
        if (run_q >= RUN_W'(LOS_RUN - 1)) los_q <= 1'b1;
      end else begin
        run_q <= '0;
        los_q <= 1'b0;
      end
    end
  end

  assign los = los_q;

  assert_los_one_clears_R2: assert property (@(posedge clk) disable iff (rst)
    (vld && !all_zero) |=> !los);
  assert_los_threshold_R1: assert property (@(posedge clk) disable iff (rst)
    (vld && all_zero && run_q == RUN_W'(LOS_RUN - 1)) |=> los);
  assert_los_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !vld |=> $stable(los));
endmodule

// File: rtl/ts16_ais_det.sv
module ts16_ais_det
  import e1_ts16_pkg::*;
#(
  parameter int OCTET_W   = 8,
  parameter int ZERO_LIM  = 4,
  parameter int CONSEC    = 2,
  parameter int PAT_BITS  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               vld,
  input  logic [OCTET_W-1:0] oct,
  input  logic               frame0,
  input  logic               aligned,
  output logic               ais
);
  localparam int ZC_W  = $clog2(ZERO_LIM + 1);
  localparam int SUM_W = $clog2(ZERO_LIM + OCTET_W + 1);
  localparam int ST_W  = $clog2(CONSEC + 1);

  logic [ZC_W-1:0]  zcnt_q;
  logic             pat_q;
  logic             open_q;
  logic [ST_W-1:0]  sparse_st_q;
  logic [ST_W-1:0]  live_st_q;
  logic             ais_q;

  logic [SUM_W-1:0] oct_zeros;
  logic [SUM_W-1:0] zsum;
  logic [ZC_W-1:0]  zsum_sat;
  logic [ZC_W-1:0]  zfresh_sat;
  logic             pat_now;
  period_verdict_e  verdict;

  always_comb begin
    oct_zeros = '0;
    for (int i = 0; i < OCTET_W; i++) begin
      if (!oct[i]) oct_zeros = oct_zeros + 1'b1;
    end
  end

  assign zsum       = SUM_W'(zcnt_q) + oct_zeros;
  assign zsum_sat   = (zsum >= SUM_W'(ZERO_LIM)) ? ZC_W'(ZERO_LIM) : ZC_W'(zsum);
  assign zfresh_sat = (oct_zeros >= SUM_W'(ZERO_LIM)) ? ZC_W'(ZERO_LIM) : ZC_W'(oct_zeros);
  assign pat_now    = (oct[OCTET_W-1 -: PAT_BITS] == '0);

  always_comb begin
    if (!open_q)                              verdict = PV_NONE;
    else if (pat_q || zcnt_q >= ZC_W'(ZERO_LIM)) verdict = PV_LIVE;
    else                                      verdict = PV_SPARSE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      zcnt_q      <= '0;
      pat_q       <= 1'b0;
      open_q      <= 1'b0;
      sparse_st_q <= '0;
      live_st_q   <= '0;
      ais_q       <= 1'b0;
    end else if (vld) begin
      if (!aligned) begin
        zcnt_q      <= '0;
        pat_q       <= 1'b0;
        open_q      <= 1'b0;
        sparse_st_q <= '0;
        live_st_q   <= '0;
        ais_q       <= 1'b0;
      end else if (frame0) begin
        case (verdict)
          PV_SPARSE: begin
            live_st_q <= '0;
            if (sparse_st_q != ST_W'(CONSEC)) sparse_st_q <= sparse_st_q + 1'b1;
            if (sparse_st_q >= ST_W'(CONSEC - 1)) ais_q <= 1'b1;
          end
          PV_LIVE: begin
            sparse_st_q <= '0;
            if (live_st_q != ST_W'(CONSEC)) live_st_q <= live_st_q + 1'b1;
            if (live_st_q >= ST_W'(CONSEC - 1)) ais_q <= 1'b0;
          end
          default: ;
        endcase
        zcnt_q <= zfresh_sat;
        pat_q  <= pat_now;
        open_q <= 1'b1;
      end else if (open_q) begin
        zcnt_q <= zsum_sat;
      end
    end
  end

  assign ais = ais_q;

  assert_ais_sync_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (vld && !aligned) |=> !ais);
  assert_ais_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !vld |=> $stable(ais));
  assert_ais_zcnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
    zcnt_q <= ZC_W'(ZERO_LIM));
  assert_ais_streak_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(sparse_st_q != '0 && live_st_q != '0));
endmodule

// File: rtl/ts16_ra_track.sv
module ts16_ra_track #(
  parameter int OCTET_W = 8,
  parameter int RA_POS  = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               vld,
  input  logic [OCTET_W-1:0] oct,
  input  logic               frame0,
  output logic               ra,
  output logic               irq
);
  localparam int RA_IDX = OCTET_W - RA_POS;

  logic ra_q;
  logic irq_q;
  logic ra_in;

  assign ra_in = oct[RA_IDX];

  always_ff @(posedge clk) begin
    if (rst) begin
      ra_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (vld && frame0) begin
        ra_q  <= ra_in;
        irq_q <= (ra_in != ra_q);
      end
    end
  end

  assign ra  = ra_q;
  assign irq = irq_q;

  assert_ra_follow_R7: assert property (@(posedge clk) disable iff (rst)
    (vld && frame0) |=> (ra == $past(ra_in)));
  assert_ra_other_frames_R7: assert property (@(posedge clk) disable iff (rst)
    !(vld && frame0) |=> $stable(ra));
  assert_irq_on_change_R8: assert property (@(posedge clk) disable iff (rst)
    irq |-> (ra != $past(ra)));
  assert_irq_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !vld |=> !irq);
endmodule

// File: rtl/e1_ts16_alarm_mon.sv
module e1_ts16_alarm_mon #(
  parameter int OCTET_W  = e1_ts16_pkg::OCTET_W_DEF,
  parameter int LOS_RUN  = 16,
  parameter int ZERO_LIM = 4,
  parameter int CONSEC   = 2,
  parameter int PAT_BITS = 4,
  parameter int RA_POS   = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ts16_vld,
  input  logic [OCTET_W-1:0] ts16_oct,
  input  logic               mf_frame0,
  input  logic               ts0_aligned,
  output logic               ts16_los,
  output logic               ts16_ais,
  output logic               ts16_ra,
  output logic               ra_chg_irq
);
  ts16_los_det #(
    .OCTET_W (OCTET_W),
    .LOS_RUN (LOS_RUN)
  ) u_los (
    .clk (clk),
    .rst (rst),
    .vld (ts16_vld),
    .oct (ts16_oct),
    .los (ts16_los)
  );

  ts16_ais_det #(
    .OCTET_W  (OCTET_W),
    .ZERO_LIM (ZERO_LIM),
    .CONSEC   (CONSEC),
    .PAT_BITS (PAT_BITS)
  ) u_ais (
    .clk     (clk),
    .rst     (rst),
    .vld     (ts16_vld),
    .oct     (ts16_oct),
    .frame0  (mf_frame0),
    .aligned (ts0_aligned),
    .ais     (ts16_ais)
  );

  ts16_ra_track #(
    .OCTET_W (OCTET_W),
    .RA_POS  (RA_POS)
  ) u_ra (
    .clk    (clk),
    .rst    (rst),
    .vld    (ts16_vld),
    .oct    (ts16_oct),
    .frame0 (mf_frame0),
    .ra     (ts16_ra),
    .irq    (ra_chg_irq)
  );

  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (!ts16_los && !ts16_ais && !ts16_ra && !ra_chg_irq));
endmodule

// File: tb/e1_ts16_alarm_mon_test.sv
module e1_ts16_alarm_mon_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       ts16_vld;
  logic [7:0] ts16_oct;
  logic       mf_frame0;
  logic       ts0_aligned;
  logic       ts16_los, ts16_ais, ts16_ra, ra_chg_irq;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  e1_ts16_alarm_mon uut (
    .clk(clk), .rst(rst), .ts16_vld(ts16_vld), .ts16_oct(ts16_oct),
    .mf_frame0(mf_frame0), .ts0_aligned(ts0_aligned),
    .ts16_los(ts16_los), .ts16_ais(ts16_ais), .ts16_ra(ts16_ra),
    .ra_chg_irq(ra_chg_irq)
  );

  task automatic check(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ts16_vld = 1'b0; ts16_oct = 8'hFF; mf_frame0 = 1'b0; ts0_aligned = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic send(input logic [7:0] o, input logic f0, input logic al);
    ts16_vld = 1'b1; ts16_oct = o; mf_frame0 = f0; ts0_aligned = al;
    @(negedge clk);
    ts16_vld = 1'b0; mf_frame0 = 1'b0;
  endtask

  task automatic run_mf(input logic [7:0] f0oct, input logic [7:0] spec, input logic [7:0] fill);
    send(f0oct, 1'b1, 1'b1);
    send(spec, 1'b0, 1'b1);
    for (int i = 0; i < 14; i++) send(fill, 1'b0, 1'b1);
  endtask

  task automatic t_reset();
    rst = 1'b1; ts16_vld = 1'b0; ts16_oct = 8'h00; mf_frame0 = 1'b0; ts0_aligned = 1'b1;
    repeat (3) @(negedge clk);
    check(ts16_los, 1'b0, "R9 reset los");
    check(ts16_ais, 1'b0, "R9 reset ais");
    check(ts16_ra, 1'b0, "R9 reset ra");
    check(ra_chg_irq, 1'b0, "R9 reset irq");
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_los();
    do_reset();
    for (int i = 0; i < 15; i++) send(8'h00, 1'b0, 1'b1);
    check(ts16_los, 1'b0, "R1 los low after 15 zeros");
    repeat (4) @(negedge clk);
    check(ts16_los, 1'b0, "R9 los unchanged without strobe");
    send(8'h00, 1'b0, 1'b1);
    check(ts16_los, 1'b1, "R1 los high after 16 zeros");
    for (int i = 0; i < 30; i++) send(8'h00, 1'b0, 1'b1);
    check(ts16_los, 1'b1, "R1 los held on long zero run");
    send(8'h01, 1'b0, 1'b1);
    check(ts16_los, 1'b0, "R2 los cleared by a one");
    for (int i = 0; i < 15; i++) send(8'h00, 1'b0, 1'b1);
    check(ts16_los, 1'b0, "R2 run restarted after one");
    send(8'h00, 1'b0, 1'b1);
    check(ts16_los, 1'b1, "R2 los sets again after fresh 16");
  endtask

  task automatic t_ais_count();
    do_reset();
    run_mf(8'hFF, 8'hF8, 8'hFF);
    run_mf(8'hFF, 8'hF8, 8'hFF);
    check(ts16_ais, 1'b0, "R3 one sparse period (3 zeros) not enough");
    run_mf(8'hFF, 8'hF8, 8'hFF);
    check(ts16_ais, 1'b1, "R3 ais set after two sparse periods");
    run_mf(8'hFF, 8'hF0, 8'hFF);
    run_mf(8'hFF, 8'hF0, 8'hFF);
    check(ts16_ais, 1'b1, "R4 one period with 4 zeros keeps ais");
    run_mf(8'hFF, 8'hF8, 8'hFF);
    check(ts16_ais, 1'b0, "R4 ais cleared after two 4-zero periods");
    run_mf(8'hFF, 8'hF0, 8'hFF);
    run_mf(8'hFF, 8'hF8, 8'hFF);
    check(ts16_ais, 1'b0, "R3 alternating periods do not set ais");
  endtask

  task automatic t_ais_pattern();
    do_reset();
    run_mf(8'hFF, 8'hFF, 8'hFF);
    run_mf(8'hFF, 8'hFF, 8'hFF);
    run_mf(8'h0F, 8'hFF, 8'hFF);
    check(ts16_ais, 1'b1, "R3 ais set on all-ones stream");
    run_mf(8'h0F, 8'hFF, 8'hFF);
    check(ts16_ais, 1'b1, "R5 one pattern period keeps ais");
    run_mf(8'hFF, 8'hFF, 8'hFF);
    check(ts16_ais, 1'b0, "R5 ais cleared by two pattern periods");
  endtask

  task automatic t_ais_sync();
    do_reset();
    run_mf(8'hFF, 8'hFF, 8'hFF);
    run_mf(8'hFF, 8'hFF, 8'hFF);
    send(8'hFF, 1'b1, 1'b1);
    check(ts16_ais, 1'b1, "R6 ais set before sync loss");
    send(8'hFF, 1'b0, 1'b0);
    check(ts16_ais, 1'b0, "R6 ais cleared on sync loss");
    run_mf(8'hFF, 8'hFF, 8'hFF);
    run_mf(8'hFF, 8'hFF, 8'hFF);
    check(ts16_ais, 1'b0, "R6 streak restarted after sync loss");
    send(8'hFF, 1'b1, 1'b1);
    check(ts16_ais, 1'b1, "R6 ais sets after two fresh periods");
  endtask

  task automatic t_ra();
    do_reset();
    send(8'h04, 1'b1, 1'b1);
    check(ts16_ra, 1'b1, "R7 ra follows bit 2 of frame-0 octet");
    check(ra_chg_irq, 1'b1, "R8 irq on ra rise");
    send(8'h00, 1'b0, 1'b1);
    check(ra_chg_irq, 1'b0, "R8 irq lasts one cycle");
    check(ts16_ra, 1'b1, "R7 non-frame-0 octet ignored");
    send(8'hFF, 1'b1, 1'b1);
    check(ts16_ra, 1'b1, "R7 ra unchanged value");
    check(ra_chg_irq, 1'b0, "R8 no irq without change");
    send(8'hFB, 1'b1, 1'b1);
    check(ts16_ra, 1'b0, "R7 ra falls with bit 2 clear");
    check(ra_chg_irq, 1'b1, "R8 irq on ra fall");
    @(negedge clk);
    check(ra_chg_irq, 1'b0, "R8 irq gone after one cycle");
    send(8'h04, 1'b0, 1'b1);
    check(ts16_ra, 1'b0, "R7 bit 2 outside frame 0 ignored");
    check(ra_chg_irq, 1'b0, "R8 no irq outside frame 0");
  endtask

  initial begin
    t_reset();
    t_los();
    t_ais_count();
    t_ais_pattern();
    t_ais_sync();
    t_ra();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule